// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

The block lays a 64x64 two-colour cursor over a stream of 32-bit display pixels. Before each scanline, while the display is in horizontal blanking, the display controller asks the block to load the cursor row for that line. The block reads the row's 16 bytes through a byte-wide video-memory read port and keeps them in a row buffer. The row holds an 8-byte AND plane and an 8-byte XOR plane. The pixels of the line then pass through the block at one per clock. Each pixel that falls inside the cursor is either replaced by a cursor colour, inverted, or left alone, according to its AND/XOR bit pair.

Software programs the cursor through a small write port. The settings are enable, screen position, hotspot, memory base and two 24-bit colours. A lock bit freezes the shape, colours and position that the overlay uses, so that several registers can be rewritten without the cursor tearing. Clipping follows the active display width and the last visible line, both supplied by the display timing logic.

Top module: `cursor_overlay`

## Requirements
- R1: The row for screen line y starts at address S + (y - Y) * 16. At that address come 8 AND-plane bytes, then 8 XOR-plane bytes. Byte k covers columns 8k to 8k+7, and its most significant bit is the leftmost column.
- R2: A cursor pixel with AND bit 1 and XOR bit 1 outputs the bitwise complement of the incoming 32-bit pixel.
- R3: A cursor pixel with AND bit 1 and XOR bit 0 outputs the incoming pixel unchanged.
- R4: A cursor pixel with AND bit 0 outputs colour 1 when its XOR bit is 1 and colour 0 otherwise, with bits [31:24] forced to 0xFF.
- R5: The overlay acts only while the enable bit (bit 0 of select 0) is set. It acts only on lines Y to Y+63 and columns X to X+63. X is taken from bits [29:16] of the position write (select 2) and Y from bits [11:0]. Every other pixel passes unchanged.
- R6: S equals the base write (select 1) masked to bits [26:4], minus the horizontal hotspot, minus 16 times the vertical hotspot. The hotspot write (select 3) gives the horizontal hotspot in bits [21:16] and the vertical hotspot in bits [5:0].
- R7: Pixels whose column is at or beyond (h_disp_field + 1) * 8 are never modified.
- R8: Lines greater than v_disp_last are never modified, and no row is fetched for them.
- R9: A base write keeps only mask 0x87FFFFF0. Colour writes (select 4 for colour 0, select 5 for colour 1) keep only bits [23:0].
- R10: Bit 31 of a base, position or hotspot write sets (1) or clears (0) the lock. While the lock is set, the base, hotspot, position and colours used by the overlay stay as they were before the locking write. Clearing the lock applies the latest written values.
- R11: out_valid and out_pix follow in_valid and in_pix one clock later. out_valid is 0 after reset.
- R12: A row load that hits the cursor issues exactly 16 byte reads on consecutive cycles while fetch_busy is high. A load that misses issues none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 base, 2 position, 3 hotspot, 4 colour 0, 5 colour 1 |
| cfg_wdata | input | 32 | Register write data |
| h_disp_field | input | 11 | Active width field; width is (field + 1) * 8 pixels |
| v_disp_last | input | 12 | Last visible line number |
| row_req | input | 1 | Pulse: load the cursor row for line row_y |
| row_y | input | 16 | Line number of the row to load |
| fetch_busy | output | 1 | Row load in progress |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 27 | Byte read address |
| mem_rdata | input | 8 | Read data, valid RD_LAT cycles after the request |
| in_valid | input | 1 | Incoming pixel valid |
| in_x | input | 16 | Column of the incoming pixel |
| in_pix | input | 32 | Incoming pixel |
| out_valid | output | 1 | Outgoing pixel valid |
| out_pix | output | 32 | Outgoing pixel |

## Verification
Each pixel result appears one clock after the pixel is presented. The bench drives a pixel on a falling edge and compares the output at the next falling edge, while presenting the next pixel at the same time. A register write reaches the overlay two clocks after its strobe: one clock for the programmed copy and one for the active copy. The bench therefore waits two extra clocks after each write before it streams pixels. A row load lasts 16 issue cycles plus the read latency plus one drain cycle. The bench polls fetch_busy at falling edges and counts the reads it sees, and it streams the line only after the load has finished.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_BASE = 3'd1,
      SEL_POS  = 3'd2,
      SEL_HOT  = 3'd3,
      SEL_CLR0 = 3'd4,
      SEL_CLR1 = 3'd5
   } cfg_sel_e;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_ISSUE,
      FS_DRAIN
   } fetch_state_e;

   localparam int LOCK_BIT = 31;

   // AND/XOR decode of one cursor pixel over the underlying pixel
   function automatic logic [31:0] blend_pixel(input logic        and_b,
                                               input logic        xor_b,
                                               input logic [31:0] under,
                                               input logic [23:0] c0,
                                               input logic [23:0] c1);
      if (and_b)
         return xor_b ? ~under : under;
      return {8'hFF, (xor_b ? c1 : c0)};
   endfunction

endpackage

// File: rtl/cursor_ovl_regs.sv
module cursor_ovl_regs
   import cursor_ovl_pkg::*;
#(
   parameter int ADDR_W = 27,
   parameter int PX_W   = 14,
   parameter int PY_W   = 12,
   parameter int HOT_W  = 6,
   parameter int ROW_B  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic              en,
   output logic [ADDR_W-1:0] act_start,
   output logic [PX_W-1:0]   act_x,
   output logic [PY_W-1:0]   act_y,
   output logic [23:0]       act_c0,
   output logic [23:0]       act_c1
);

   localparam int ALIGN_LSB = $clog2(ROW_B);

   // programmed copy
   logic [ADDR_W-1:ALIGN_LSB] base_q;
   logic                      lock_q;
   logic [PX_W-1:0]           x_q;
   logic [PY_W-1:0]           y_q;
   logic [HOT_W-1:0]          hx_q;
   logic [HOT_W-1:0]          hy_q;
   logic [23:0]               c0_q;
   logic [23:0]               c1_q;
   logic [ADDR_W-1:0]         start_calc;
   logic                      unused_wdata;

   assign unused_wdata = ^cfg_wdata;

   always_comb begin
      start_calc = {base_q, {ALIGN_LSB{1'b0}}}
                 - ADDR_W'(hx_q)
                 - ADDR_W'(hy_q) * ADDR_W'(ROW_B);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         base_q <= '0;
         lock_q <= 1'b0;
         x_q    <= '0;
         y_q    <= '0;
         hx_q   <= '0;
         hy_q   <= '0;
         c0_q   <= '0;
         c1_q   <= '0;
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_sel))
            SEL_CTRL: en <= cfg_wdata[0];
            SEL_BASE: begin
               base_q <= cfg_wdata[ADDR_W-1:ALIGN_LSB];
               lock_q <= cfg_wdata[LOCK_BIT];
            end
            SEL_POS: begin
               x_q    <= cfg_wdata[16 +: PX_W];
               y_q    <= cfg_wdata[0 +: PY_W];
               lock_q <= cfg_wdata[LOCK_BIT];
            end
            SEL_HOT: begin
               hx_q   <= cfg_wdata[16 +: HOT_W];
               hy_q   <= cfg_wdata[0 +: HOT_W];
               lock_q <= cfg_wdata[LOCK_BIT];
            end
            SEL_CLR0: c0_q <= cfg_wdata[23:0];
            SEL_CLR1: c1_q <= cfg_wdata[23:0];
            default: ;
         endcase
      end
   end

   // active copy follows the programmed copy only while unlocked
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_start <= '0;
         act_x     <= '0;
         act_y     <= '0;
         act_c0    <= '0;
         act_c1    <= '0;
      end else if (!lock_q) begin
         act_start <= start_calc;
         act_x     <= x_q;
         act_y     <= y_q;
         act_c0    <= c0_q;
         act_c1    <= c1_q;
      end
   end

endmodule

// File: rtl/cursor_ovl_fetch.sv
module cursor_ovl_fetch
   import cursor_ovl_pkg::*;
#(
   parameter int ADDR_W   = 27,
   parameter int COORD_W  = 16,
   parameter int PY_W     = 12,
   parameter int VF_W     = 12,
   parameter int CUR_SIZE = 64,
   parameter int RD_LAT   = 1,
   localparam int ROW_B   = 2 * (CUR_SIZE / 8),
   localparam int IDX_W   = $clog2(ROW_B)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic [ADDR_W-1:0]          act_start,
   input  logic [PY_W-1:0]            act_y,
   input  logic [VF_W-1:0]            v_last,
   input  logic                       row_req,
   input  logic [COORD_W-1:0]         row_y,
   output logic                       busy,
   output logic                       mem_rd,
   output logic [ADDR_W-1:0]          mem_addr,
   input  logic [7:0]                 mem_rdata,
   output logic                       row_hit,
   output logic [ROW_B-1:0][7:0]      row_bits
);

   fetch_state_e                   st;
   logic [IDX_W-1:0]               issue_idx;
   logic [ADDR_W-1:0]              row_addr;
   logic [ADDR_W-1:0]              row_addr_calc;
   logic [COORD_W-1:0]             dy;
   logic                           hit;
   logic [RD_LAT-1:0]              pend;
   logic [RD_LAT-1:0][IDX_W-1:0]   pidx;

   always_comb begin
      dy            = row_y - COORD_W'(act_y);
      hit           = en
                   && (row_y >= COORD_W'(act_y))
                   && (dy < COORD_W'(CUR_SIZE))
                   && (row_y <= COORD_W'(v_last));
      row_addr_calc = act_start + ADDR_W'(dy) * ADDR_W'(ROW_B);
   end

   assign busy     = (st != FS_IDLE);
   assign mem_rd   = (st == FS_ISSUE);
   assign mem_addr = row_addr + ADDR_W'(issue_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= FS_IDLE;
         issue_idx <= '0;
         row_addr  <= '0;
         row_hit   <= 1'b0;
         pend      <= '0;
         pidx      <= '0;
         row_bits  <= '0;
      end else begin
         pend    <= (pend << 1) | RD_LAT'(mem_rd);
         pidx[0] <= issue_idx;
         for (int k = 1; k < RD_LAT; k++)
            pidx[k] <= pidx[k-1];
         if (pend[RD_LAT-1])
            row_bits[pidx[RD_LAT-1]] <= mem_rdata;

         case (st)
            FS_IDLE: begin
               if (row_req) begin
                  row_hit <= 1'b0;
                  if (hit) begin
                     row_addr  <= row_addr_calc;
                     issue_idx <= '0;
                     st        <= FS_ISSUE;
                  end
               end
            end
            FS_ISSUE: begin
               issue_idx <= issue_idx + 1'b1;
               if (issue_idx == IDX_W'(ROW_B - 1))
                  st <= FS_DRAIN;
            end
            FS_DRAIN: begin
               if (pend == '0) begin
                  st      <= FS_IDLE;
                  row_hit <= 1'b1;
               end
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cursor_ovl_mix.sv
module cursor_ovl_mix
   import cursor_ovl_pkg::*;
#(
   parameter int COORD_W  = 16,
   parameter int PX_W     = 14,
   parameter int HF_W     = 11,
   parameter int CUR_SIZE = 64,
   parameter bit OUT_REG  = 1'b1,
   localparam int PLANE_B = CUR_SIZE / 8,
   localparam int ROW_B   = 2 * PLANE_B,
   localparam int IDX_W   = $clog2(ROW_B),
   localparam int COL_W   = $clog2(CUR_SIZE),
   localparam int AW_W    = HF_W + 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic                  row_hit,
   input  logic [ROW_B-1:0][7:0] row_bits,
   input  logic [PX_W-1:0]       act_x,
   input  logic [23:0]           act_c0,
   input  logic [23:0]           act_c1,
   input  logic [HF_W-1:0]       h_field,
   input  logic                  in_valid,
   input  logic [COORD_W-1:0]    in_x,
   input  logic [31:0]           in_pix,
   output logic                  out_valid,
   output logic [31:0]           out_pix
);

   logic [AW_W-1:0]    act_w;
   logic [COORD_W-1:0] col_full;
   logic [COL_W-1:0]   col;
   logic [IDX_W-1:0]   and_idx;
   logic [7:0]         and_byte;
   logic [7:0]         xor_byte;
   logic               in_cur;
   logic [31:0]        mixed;

   always_comb begin
      act_w    = (AW_W'(h_field) + AW_W'(1)) << 3;
      col_full = in_x - COORD_W'(act_x);
      col      = col_full[COL_W-1:0];
      and_idx  = IDX_W'(col[COL_W-1:3]);
      and_byte = row_bits[and_idx];
      xor_byte = row_bits[and_idx + IDX_W'(PLANE_B)];
      in_cur   = en && row_hit
              && (in_x >= COORD_W'(act_x))
              && (col_full < COORD_W'(CUR_SIZE))
              && (in_x < COORD_W'(act_w));
      mixed    = in_cur ? blend_pixel(and_byte[~col[2:0]], xor_byte[~col[2:0]],
                                      in_pix, act_c0, act_c1)
                        : in_pix;
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
         end else begin
            out_valid <= in_valid;
            out_pix   <= mixed;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         out_valid = in_valid;
         out_pix   = mixed;
      end
   end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_ovl_pkg::*;
#(
   parameter int ADDR_W   = 27,
   parameter int COORD_W  = 16,
   parameter int PX_W     = 14,
   parameter int PY_W     = 12,
   parameter int HOT_W    = 6,
   parameter int HF_W     = 11,
   parameter int VF_W     = 12,
   parameter int CUR_SIZE = 64,
   parameter int RD_LAT   = 1,
   parameter bit OUT_REG  = 1'b1,
   localparam int ROW_B   = 2 * (CUR_SIZE / 8)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [31:0]        cfg_wdata,
   input  logic [HF_W-1:0]    h_disp_field,
   input  logic [VF_W-1:0]    v_disp_last,
   input  logic               row_req,
   input  logic [COORD_W-1:0] row_y,
   output logic               fetch_busy,
   output logic               mem_rd,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [7:0]         mem_rdata,
   input  logic               in_valid,
   input  logic [COORD_W-1:0] in_x,
   input  logic [31:0]        in_pix,
   output logic               out_valid,
   output logic [31:0]        out_pix
);

   if (CUR_SIZE < 8 || (CUR_SIZE % 8) != 0 || (CUR_SIZE & (CUR_SIZE - 1)) != 0)
      begin : g_bad_size  $error("CUR_SIZE must be a power of two of at least 8"); end
   if (ADDR_W > LOCK_BIT)
      begin : g_bad_addr  $error("ADDR_W must leave bit 31 free for the lock"); end
   if (16 + PX_W > LOCK_BIT || 16 + HOT_W > LOCK_BIT || PY_W > 16 || HOT_W > 16)
      begin : g_bad_field $error("register fields overlap"); end
   if (COORD_W < HF_W + 4 || COORD_W < PX_W || COORD_W < PY_W || COORD_W < VF_W)
      begin : g_bad_coord $error("COORD_W too narrow"); end
   if (RD_LAT < 1)
      begin : g_bad_lat   $error("RD_LAT must be at least 1"); end

   logic                  ctl_en;
   logic [ADDR_W-1:0]     act_start;
   logic [PX_W-1:0]       act_x;
   logic [PY_W-1:0]       act_y;
   logic [23:0]           act_c0;
   logic [23:0]           act_c1;
   logic                  row_hit;
   logic [ROW_B-1:0][7:0] row_bits;

   cursor_ovl_regs #(
      .ADDR_W(ADDR_W), .PX_W(PX_W), .PY_W(PY_W), .HOT_W(HOT_W), .ROW_B(ROW_B)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .en(ctl_en), .act_start(act_start), .act_x(act_x), .act_y(act_y),
      .act_c0(act_c0), .act_c1(act_c1)
   );

   cursor_ovl_fetch #(
      .ADDR_W(ADDR_W), .COORD_W(COORD_W), .PY_W(PY_W), .VF_W(VF_W),
      .CUR_SIZE(CUR_SIZE), .RD_LAT(RD_LAT)
   ) fetch_i (
      .clk(clk), .rst_n(rst_n), .en(ctl_en),
      .act_start(act_start), .act_y(act_y), .v_last(v_disp_last),
      .row_req(row_req), .row_y(row_y), .busy(fetch_busy),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .row_hit(row_hit), .row_bits(row_bits)
   );

   cursor_ovl_mix #(
      .COORD_W(COORD_W), .PX_W(PX_W), .HF_W(HF_W), .CUR_SIZE(CUR_SIZE), .OUT_REG(OUT_REG)
   ) mix_i (
      .clk(clk), .rst_n(rst_n), .en(ctl_en),
      .row_hit(row_hit), .row_bits(row_bits),
      .act_x(act_x), .act_c0(act_c0), .act_c1(act_c1),
      .h_field(h_disp_field),
      .in_valid(in_valid), .in_x(in_x), .in_pix(in_pix),
      .out_valid(out_valid), .out_pix(out_pix)
   );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
   parameter int COORD_W = 16,
   parameter int HF_W    = 11,
   parameter int ROW_B   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic [HF_W-1:0]    h_field,
   input logic               in_valid,
   input logic [COORD_W-1:0] in_x,
   input logic [31:0]        in_pix,
   input logic               out_valid,
   input logic [31:0]        out_pix,
   input logic               fetch_busy,
   input logic               mem_rd
);

   localparam int AW_W = HF_W + 4;

   logic [AW_W-1:0] clip_w;
   logic [7:0]      rd_cnt;

   always_comb clip_w = AW_W'((32'(h_field) + 32'd1) * 32'd8);

   always_ff @(posedge clk) begin
      if (!rst_n)          rd_cnt <= '0;
      else if (fetch_busy) rd_cnt <= rd_cnt + 8'(mem_rd);
      else                 rd_cnt <= '0;
   end

   assert_rd_in_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> fetch_busy);

   assert_rd_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fetch_busy) |-> (rd_cnt == 8'(ROW_B)));

   if (OUT_REG) begin : g_lat
      assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      assert_idle_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);

      assert_disabled_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !en) |=> (out_pix == $past(in_pix)));

      assert_right_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (in_x >= COORD_W'(clip_w))) |=> (out_pix == $past(in_pix)));

      assert_pixel_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> ((out_pix == $past(in_pix)) || (out_pix == ~$past(in_pix))
                       || (out_pix[31:24] == 8'hFF)));
   end

endmodule

bind cursor_overlay cursor_overlay_chk #(
   .COORD_W(COORD_W), .HF_W(HF_W), .ROW_B(ROW_B), .OUT_REG(OUT_REG)
) chk_i (
   .clk(clk), .rst_n(rst_n), .en(ctl_en), .h_field(h_disp_field),
   .in_valid(in_valid), .in_x(in_x), .in_pix(in_pix),
   .out_valid(out_valid), .out_pix(out_pix),
   .fetch_busy(fetch_busy), .mem_rd(mem_rd)
);

// File: tb/cursor_overlay_tb_top.sv
module cursor_overlay_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [10:0] h_disp_field = 11'd15;
   logic [11:0] v_disp_last = 12'd200;
   logic        row_req = 1'b0;
   logic [15:0] row_y = '0;
   logic        fetch_busy;
   logic        mem_rd;
   logic [26:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        in_valid = 1'b0;
   logic [15:0] in_x = '0;
   logic [31:0] in_pix = '0;
   logic        out_valid;
   logic [31:0] out_pix;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] bmem [4096];

   // model: programmed and active settings
   logic        m_en = 0, m_lock = 0;
   logic [31:0] m_base = 0;
   int          m_x = 0, m_y = 0, m_hx = 0, m_hy = 0;
   logic [23:0] m_c0 = 0, m_c1 = 0;
   logic [31:0] a_base = 0;
   int          a_x = 0, a_y = 0, a_hx = 0, a_hy = 0;
   logic [23:0] a_c0 = 0, a_c1 = 0;

   always #5 clk = ~clk;

   cursor_overlay dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .h_disp_field(h_disp_field), .v_disp_last(v_disp_last),
      .row_req(row_req), .row_y(row_y), .fetch_busy(fetch_busy),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .in_valid(in_valid), .in_x(in_x), .in_pix(in_pix),
      .out_valid(out_valid), .out_pix(out_pix)
   );

   // video memory responder, one cycle read latency
   always @(posedge clk) if (mem_rd) mem_rdata <= bmem[int'(mem_addr[11:0])];

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         3'd0: m_en = d[0];
         3'd1: begin m_base = d & 32'h87FFFFF0; m_lock = d[31]; end
         3'd2: begin m_x = int'(d[29:16]); m_y = int'(d[11:0]); m_lock = d[31]; end
         3'd3: begin m_hx = int'(d[21:16]); m_hy = int'(d[5:0]); m_lock = d[31]; end
         3'd4: m_c0 = d[23:0];
         3'd5: m_c1 = d[23:0];
         default: ;
      endcase
      if (!m_lock) begin
         a_base = m_base; a_x = m_x; a_y = m_y; a_hx = m_hx; a_hy = m_hy;
         a_c0 = m_c0; a_c1 = m_c1;
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   function automatic bit row_hits(input int y);
      return m_en && (y >= a_y) && (y < a_y + 64) && (y <= int'(v_disp_last));
   endfunction

   function automatic logic [31:0] exp_pix(input int y, input int x, input logic [31:0] bg,
                                           output string tag);
      int aw, col, dy, start, ai, xi;
      logic ab, xb;
      aw = (int'(h_disp_field) + 1) * 8;
      tag = "R5";
      if (!m_en) return bg;
      if (y < a_y || y >= a_y + 64) return bg;
      if (y > int'(v_disp_last)) begin tag = "R8"; return bg; end
      if (x < a_x || x >= a_x + 64) return bg;
      if (x >= aw) begin tag = "R7"; return bg; end
      col   = x - a_x;
      dy    = y - a_y;
      start = int'(a_base & 32'h07FFFFF0) - a_hx - a_hy * 16 + dy * 16;
      ai    = (start + col / 8) & 32'hFFF;
      xi    = (start + 8 + col / 8) & 32'hFFF;
      ab    = bmem[ai][7 - (col % 8)];
      xb    = bmem[xi][7 - (col % 8)];
      if (ab && xb) begin tag = "R2 (R1 R6)"; return ~bg; end
      if (ab)       begin tag = "R3 (R1 R6)"; return bg; end
      tag = "R4 R9 (R1 R6)";
      return {8'hFF, (xb ? a_c1 : a_c0)};
   endfunction

   task automatic run_line(input string ctx, input int y, input int nx);
      int nrd;
      logic [31:0] bg, prev_exp;
      string tag;
      bit exp_hit;
      exp_hit = row_hits(y);
      @(negedge clk);
      row_req = 1'b1; row_y = 16'(y);
      @(negedge clk);
      row_req = 1'b0;
      nrd = 0;
      while (fetch_busy) begin
         if (mem_rd) nrd++;
         @(negedge clk);
      end
      check(nrd == (exp_hit ? 16 : 0), {ctx, " R12 read count"}, 32'(nrd), exp_hit ? 32'd16 : 32'd0);
      tag = "";
      prev_exp = '0;
      for (int x = 0; x <= nx; x++) begin
         if (x > 0) begin
            if (!(out_valid && out_pix == prev_exp))
               $display("  at line %0d column %0d", y, x - 1);
            check(out_valid && out_pix == prev_exp, {ctx, " ", tag}, out_pix, prev_exp);
         end
         if (x < nx) begin
            bg = $urandom;
            in_valid = 1'b1; in_x = 16'(x); in_pix = bg;
            prev_exp = exp_pix(y, x, bg, tag);
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
      end
      check(!out_valid, {ctx, " R11 valid drops"}, 32'(out_valid), 32'd0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h0C0FFEE1));
      for (int i = 0; i < 4096; i++) bmem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R11 reset out_valid", 32'(out_valid), 32'd0);
      check(fetch_busy == 1'b0 && mem_rd == 1'b0, "R12 reset idle",
            {30'd0, fetch_busy, mem_rd}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed setup: junk in masked-off bits
      cfg_write(3'd0, 32'h1);
      cfg_write(3'd1, 32'h780008AB);
      cfg_write(3'd4, 32'hAB123456);
      cfg_write(3'd5, 32'hCD654321);
      cfg_write(3'd2, (32'd20 << 16) | 32'd10);
      cfg_write(3'd3, (32'd3 << 16) | 32'd2);

      run_line("R5 above", 9, 100);
      run_line("R5 first", 10, 100);
      run_line("main", 11, 100);
      run_line("main", 40, 100);
      run_line("R5 last", 73, 100);
      run_line("R5 below", 74, 100);

      // right-edge clip: width 128, cursor at 100
      cfg_write(3'd2, (32'd100 << 16) | 32'd10);
      run_line("R7 edge", 12, 140);

      // bottom clip
      v_disp_last = 12'd30;
      run_line("R8 last visible", 30, 100);
      run_line("R8 hidden", 31, 100);
      v_disp_last = 12'd200;

      // disabled
      cfg_write(3'd0, 32'h0);
      run_line("R5 disabled", 20, 100);
      cfg_write(3'd0, 32'h1);

      // lock: new values held off, then released
      cfg_write(3'd2, 32'h80000000 | (32'd40 << 16) | 32'd10);
      cfg_write(3'd4, 32'h0000FF00);
      cfg_write(3'd1, 32'h80000C00);
      run_line("R10 locked", 15, 140);
      cfg_write(3'd3, (32'd5 << 16) | 32'd1);
      run_line("R10 released", 15, 140);

      // constrained random
      for (int it = 0; it < 6; it++) begin
         h_disp_field = 11'(8 + ($urandom % 17));
         v_disp_last  = 12'(40 + ($urandom % 200));
         cfg_write(3'd1, 32'h0800 | ($urandom & 32'h7800F7F0));
         cfg_write(3'd3, (($urandom % 64) << 16) | ($urandom % 64));
         cfg_write(3'd4, $urandom);
         cfg_write(3'd5, $urandom);
         cfg_write(3'd2, (($urandom % 160) << 16) | ($urandom % 100));
         for (int l = 0; l < 3; l++) begin
            int yy;
            yy = m_y - 2 + int'($urandom % 68);
            if (yy < 0) yy = 0;
            run_line("random", yy, 200);
         end
      end

      done = 1'b1;
      finish_run();
   end

endmodule